// File: doc/BRIEF.md
# Bus-Written Four-Digit Seven-Segment Store

This block keeps four display characters, each held as a ready-to-drive seven-segment pattern. A processor writes it through a small bus. Each write carries a 4-bit value, a 2-bit digit address and a pair of active-low selects. While both selects are low, the value and the address are held in an input buffer. When either select is released, the buffered value is decoded and stored in the addressed digit.

All bus inputs pass through a two-stage synchronizer into the system clock. A build-time parameter picks the character set. One set gives the sixteen hexadecimal glyphs. The other gives the decimal digits plus dash, E, H, L, P and blank. A second parameter replaces the bus with four active-high per-digit strobes. Each strobe loads its own digit straight from the live input value for as long as it is high.

Top module: `segbank_top`

## Requirements
- R1: After reset all four segment outputs hold the blank pattern 7'h00. Segment bits are packed {g,f,e,d,c,b,a}, where a is the top bar, g is the middle bar and 1 means lit.
- R2: With ALT_CODE=0, input values 0..15 decode to the glyphs 0-9 and A, b, C, d, E, F, in codes 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R3: With ALT_CODE=1, values 0..9 decode exactly as in R2. Values 10..15 decode to dash 40, E 79, H 76, L 38, P 73 and blank 00.
- R4: In bus mode the value and the address are taken into the buffer only while both selects are low. Input changes made while either select is high do not alter what is written.
- R5: In bus mode a write occurs when either select rises out of the both-low state. Raising select 0 first and raising select 1 first both commit the write.
- R6: The address map is reversed: address 11 writes segDig0 (the least significant digit), 10 writes segDig1, 01 writes segDig2 and 00 writes segDig3.
- R7: A write changes only the addressed digit. The other three keep their patterns.
- R8: Each both-low period gives exactly one write. Toggling one select while the other stays high writes nothing.
- R9: With STROBED=1, while digStb[i] is high, digit i (segDig0 for i=0) follows the decoded live value. After the strobe falls, the digit keeps its last pattern even when the value changes.
- R10: In bus mode the digit strobes have no effect. In strobed mode the selects and the address have no effect.
- R11: A committed write shows on the outputs within four clock cycles of the select or strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dataIn | input | 4 | Character value, true binary, bit 0 least significant |
| digAddr | input | 2 | Digit address for bus writes (reversed map) |
| selN | input | 2 | Two active-low selects; the write is taken while both are low |
| digStb | input | 4 | Active-high per-digit load strobes (strobed mode) |
| segDig0 | output | 7 | Least significant digit, {g,f,e,d,c,b,a} |
| segDig1 | output | 7 | Second digit |
| segDig2 | output | 7 | Third digit |
| segDig3 | output | 7 | Most significant digit |

## Verification
The bus instance is written with every value 0 to 15, spread over all four addresses. This tells each hex glyph apart and shows that the reversed address map lands each value in a distinct output. The writes alternate which select rises first. After the release, the data is flipped and a lone select is toggled with the other held high; these separate a true commit-on-release from a write that follows the pins or a spurious extra write. A second instance, in strobed mode with the alternate character set, loads values 10 to 15 by strobe. The value then changes after the strobe falls, which distinguishes the alternate glyphs and shows that a digit holds once its strobe is low. On each instance, the inputs of the other mode are toggled to show they have no effect.

// File: rtl/segbank_pkg.sv
package segbank_pkg;
  localparam int NIB_W  = 4;
  localparam int SEG_W  = 7;
  localparam int NUM_DIG = 4;
  localparam int ADDR_W = $clog2(NUM_DIG);

  typedef logic [SEG_W-1:0] seg_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic               loadBuf;
    logic [NUM_DIG-1:0] digLoad;
  } ctrl_strobe_t;

  localparam seg_t SEG_BLANK = 7'h00;

  // bit order {g,f,e,d,c,b,a}, 1 = lit
  function automatic seg_t decodeHex(input logic [NIB_W-1:0] n);
    seg_t s;
    case (n)
      4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
      4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
      4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
      4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  default: s = 7'h71;
    endcase
    return s;
  endfunction

  function automatic seg_t decodeAlt(input logic [NIB_W-1:0] n);
    seg_t s;
    case (n)
      4'hA: s = 7'h40;      // dash
      4'hB: s = 7'h79;      // E
      4'hC: s = 7'h76;      // H
      4'hD: s = 7'h38;      // L
      4'hE: s = 7'h73;      // P
      4'hF: s = SEG_BLANK;  // blank
      default: s = decodeHex(n);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/segbank_sync.sv
module segbank_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stages [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stages[i] <= RST_VAL;
    end else begin
      stages[0] <= d;
      for (int i = 1; i < DEPTH; i++) stages[i] <= stages[i-1];
    end
  end

  assign q = stages[DEPTH-1];
endmodule

// File: rtl/segbank_ctrl.sv
module segbank_ctrl
  import segbank_pkg::*;
#(
  parameter bit STROBED = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          selS,
  input  logic [ADDR_W-1:0]   addrS,
  input  logic [NUM_DIG-1:0]  stbS,
  output ctrl_strobe_t        strobes
);
  logic              bothLow;
  logic              prevBothLow;
  logic              wrPulse;
  logic [ADDR_W-1:0] bufAddr;
  logic [ADDR_W-1:0] digIdx;

  assign bothLow = (selS == 2'b00);
  assign wrPulse = prevBothLow && !bothLow;
  // reversed map: highest address names the least significant digit
  assign digIdx  = ADDR_W'(NUM_DIG - 1) - bufAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBothLow <= 1'b0;
      bufAddr     <= '0;
    end else begin
      prevBothLow <= bothLow;
      if (bothLow) bufAddr <= addrS;
    end
  end

  generate
    if (STROBED) begin : g_strobed
      always_comb begin
        strobes.loadBuf = 1'b0;
        strobes.digLoad = stbS;
      end
    end else begin : g_bus
      always_comb begin
        strobes.loadBuf = bothLow;
        strobes.digLoad = '0;
        if (wrPulse) strobes.digLoad[digIdx] = 1'b1;
      end

      assert_one_write_R8: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(strobes.digLoad));
      assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.digLoad != '0) |=> (strobes.digLoad == '0));
      assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.loadBuf |=> $stable(bufAddr));
    end
  endgenerate
endmodule

// File: rtl/segbank_dp.sv
module segbank_dp
  import segbank_pkg::*;
#(
  parameter bit STROBED  = 1'b0,
  parameter bit ALT_CODE = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NIB_W-1:0]   dataS,
  input  ctrl_strobe_t       strobes,
  output seg_t [NUM_DIG-1:0] digits
);
  logic [NIB_W-1:0] bufData;
  logic [NIB_W-1:0] srcData;
  seg_t             decoded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bufData <= '0;
    else if (strobes.loadBuf) bufData <= dataS;
  end

  generate
    if (STROBED) begin : g_src_live
      assign srcData = dataS;
    end else begin : g_src_buf
      assign srcData = bufData;
    end
    if (ALT_CODE) begin : g_alt
      assign decoded = decodeAlt(srcData);
    end else begin : g_hex
      assign decoded = decodeHex(srcData);
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   digits[i] <= SEG_BLANK;
        else if (strobes.digLoad[i]) digits[i] <= decoded;
      end

      assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.digLoad[i] |=> $stable(digits[i]));
    end
  endgenerate

  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadBuf |=> $stable(bufData));
endmodule

// File: rtl/segbank_top.sv
module segbank_top
  import segbank_pkg::*;
#(
  parameter bit ALT_CODE   = 1'b0,
  parameter bit STROBED    = 1'b0,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  dataIn,
  input  logic [ADDR_W-1:0] digAddr,
  input  logic [1:0]        selN,
  input  logic [NUM_DIG-1:0] digStb,
  output logic [SEG_W-1:0]  segDig0,
  output logic [SEG_W-1:0]  segDig1,
  output logic [SEG_W-1:0]  segDig2,
  output logic [SEG_W-1:0]  segDig3
);
  localparam int IN_W = NIB_W + ADDR_W + 2 + NUM_DIG;
  localparam logic [IN_W-1:0] IN_RST = {{(NIB_W+ADDR_W){1'b0}}, 2'b11, {NUM_DIG{1'b0}}};

  logic [IN_W-1:0]    rawIn, syncIn;
  logic [NIB_W-1:0]   dataS;
  logic [ADDR_W-1:0]  addrS;
  logic [1:0]         selS;
  logic [NUM_DIG-1:0] stbS;
  ctrl_strobe_t       strobes;
  seg_t [NUM_DIG-1:0] digits;

  assign rawIn = {dataIn, digAddr, selN, digStb};
  assign {dataS, addrS, selS, stbS} = syncIn;

  segbank_sync #(.W(IN_W), .DEPTH(SYNC_DEPTH), .RST_VAL(IN_RST)) sync_i (
    .clk(clk), .rstN(rstN), .d(rawIn), .q(syncIn));

  segbank_ctrl #(.STROBED(STROBED)) ctrl_i (
    .clk(clk), .rstN(rstN), .selS(selS), .addrS(addrS), .stbS(stbS),
    .strobes(strobes));

  segbank_dp #(.STROBED(STROBED), .ALT_CODE(ALT_CODE)) dp_i (
    .clk(clk), .rstN(rstN), .dataS(dataS), .strobes(strobes), .digits(digits));

  assign segDig0 = digits[0];
  assign segDig1 = digits[1];
  assign segDig2 = digits[2];
  assign segDig3 = digits[3];
endmodule

// File: tb/segbank_top_tb_top.sv
module segbank_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // bus-mode hex instance
  logic [3:0] dataA = '0;
  logic [1:0] addrA = '0;
  logic [1:0] selA  = 2'b11;
  logic [3:0] stbA  = '0;
  logic [6:0] a0, a1, a2, a3;
  // strobed alt-code instance
  logic [3:0] dataB = '0;
  logic [1:0] addrB = '0;
  logic [1:0] selB  = 2'b11;
  logic [3:0] stbB  = '0;
  logic [6:0] b0, b1, b2, b3;

  segbank_top #(.ALT_CODE(1'b0), .STROBED(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .dataIn(dataA), .digAddr(addrA), .selN(selA),
    .digStb(stbA), .segDig0(a0), .segDig1(a1), .segDig2(a2), .segDig3(a3));

  segbank_top #(.ALT_CODE(1'b1), .STROBED(1'b1)) dutStb_i (
    .clk(clk), .rstN(rstN), .dataIn(dataB), .digAddr(addrB), .selN(selB),
    .digStb(stbB), .segDig0(b0), .segDig1(b1), .segDig2(b2), .segDig3(b3));

  typedef struct {
    string      req;
    bit         onStb;
    logic [27:0] exp;
  } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [6:0] modA [4];
  logic [6:0] modB [4];

  function automatic logic [6:0] hexGlyph(input int n);
    case (n)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [6:0] altGlyph(input int n);
    case (n)
      10: return 7'h40; 11: return 7'h79; 12: return 7'h76;
      13: return 7'h38; 14: return 7'h73; 15: return 7'h00;
      default: return hexGlyph(n);
    endcase
  endfunction

  task automatic push(input string req, input bit onStb);
    item_t it;
    it.req = req;
    it.onStb = onStb;
    it.exp = onStb ? {modB[3], modB[2], modB[1], modB[0]}
                   : {modA[3], modA[2], modA[1], modA[0]};
    scoreQ.push_back(it);
  endtask

  // monitor: compares popped expectations away from the rising edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      item_t it;
      logic [27:0] act;
      it = scoreQ.pop_front();
      act = it.onStb ? {b3, b2, b1, b0} : {a3, a2, a1, a0};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  // bus write; relFirst picks which select rises first
  task automatic busWrite(input logic [1:0] addr, input logic [3:0] val,
                          input int relFirst, input string req);
    @(negedge clk);
    dataA = val; addrA = addr; selA = 2'b00;
    repeat (3) @(negedge clk);
    selA[relFirst] = 1'b1;
    @(negedge clk);
    dataA = ~val; addrA = ~addr;   // changed after release: must be ignored (R4)
    repeat (2) @(negedge clk);
    selA = 2'b11;
    repeat (5) @(negedge clk);
    modA[3 - addr] = hexGlyph(val);
    push(req, 1'b0);
  endtask

  task automatic stbLoad(input int idx, input logic [3:0] val, input string req);
    @(negedge clk);
    dataB = val; stbB = 4'b0001 << idx;
    repeat (4) @(negedge clk);
    stbB = '0;
    repeat (2) @(negedge clk);
    dataB = ~val;                  // after strobe fell: digit must hold (R9)
    repeat (6) @(negedge clk);
    modB[idx] = altGlyph(val);
    push(req, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin modA[i] = 7'h00; modB[i] = 7'h00; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    push("R1 reset blank bus", 1'b0);
    push("R1 reset blank strobed", 1'b1);

    // R2/R5/R6/R7: every hex value, cycling addresses and release order
    for (int v = 0; v < 16; v++) begin
      busWrite(2'(v), 4'(v), v % 2, "R2 R5 R6 R7 bus write");
    end

    // R6 explicit address map
    busWrite(2'b11, 4'h1, 0, "R6 addr 11 -> digit0");
    busWrite(2'b00, 4'h8, 1, "R6 addr 00 -> digit3");

    // R8: lone select toggles with other high, data differs: no write
    @(negedge clk);
    dataA = 4'h0; addrA = 2'b11;
    for (int k = 0; k < 3; k++) begin
      selA = 2'b10; repeat (3) @(negedge clk);
      selA = 2'b11; repeat (3) @(negedge clk);
      selA = 2'b01; repeat (3) @(negedge clk);
      selA = 2'b11; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    push("R8 no write without both low", 1'b0);

    // R10: strobes on bus instance ignored
    stbA = 4'hF; dataA = 4'h3;
    repeat (8) @(negedge clk);
    stbA = '0;
    repeat (4) @(negedge clk);
    push("R10 strobes ignored in bus mode", 1'b0);

    // R11: write visible within four cycles of release
    @(negedge clk);
    dataA = 4'hC; addrA = 2'b10; selA = 2'b00;
    repeat (3) @(negedge clk);
    selA = 2'b11;
    repeat (4) @(negedge clk);
    modA[1] = hexGlyph(12);
    push("R11 latency", 1'b0);

    // R3/R9 on strobed instance: alt codes 10..15 and a decimal
    stbLoad(0, 4'hA, "R3 R9 dash");
    stbLoad(1, 4'hB, "R3 R9 E");
    stbLoad(2, 4'hC, "R3 R9 H");
    stbLoad(3, 4'hD, "R3 R9 L");
    stbLoad(0, 4'hE, "R3 R9 P");
    stbLoad(1, 4'h7, "R3 decimal 7");
    stbLoad(2, 4'hF, "R3 R9 blank");

    // R9: digit follows live value while strobe held
    @(negedge clk);
    stbB = 4'b1000; dataB = 4'h2;
    repeat (5) @(negedge clk);
    modB[3] = altGlyph(2);
    push("R9 follow while high (first)", 1'b1);
    dataB = 4'h5;
    repeat (5) @(negedge clk);
    modB[3] = altGlyph(5);
    push("R9 follow while high (second)", 1'b1);
    stbB = '0;
    repeat (4) @(negedge clk);

    // R10: selects and address ignored in strobed mode
    dataB = 4'h9; addrB = 2'b11; selB = 2'b00;
    repeat (4) @(negedge clk);
    selB = 2'b11;
    repeat (6) @(negedge clk);
    push("R10 selects ignored in strobed mode", 1'b1);

    while (scoreQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule